// File: doc/BRIEF.md
# Lines-Per-Frame Serial Reporter

This block watches an active-low horizontal sync and an active-low vertical sync, both already synchronous to the system clock. It counts the horizontal sync leading edges (high-to-low transitions) that fall within one field. It doubles that count to estimate the lines in a two-field frame and reports the result on a single serial output pin.

The block applies the doubling whether the source is interlaced or progressive. Decoding the number into a video format is left to the receiver. A progressive source shows up as twice its real line count.

At each vertical sync leading edge the count for the field just ended is frozen, and the counter starts again from zero. After the following vertical sync trailing edge, the frozen 11-bit value is sent most significant bit first. Each bit is launched by one of the next 11 horizontal sync leading edges. Outside those bit slots the pin stays low. If a new vertical sync begins before all bits are out, the rest of the word is dropped.

Top module: `lpf_reporter`

## Requirements
- R1: At each vertical sync leading edge the block freezes the value 2*N. N is the number of horizontal sync leading edges seen after the previous vertical sync leading edge, up to and including one that falls in the same clock cycle as the current vertical sync leading edge. The counter then restarts at zero, so edges seen while vertical sync is low belong to the next field.
- R2: When 2*N exceeds 2047, the frozen value is 2047.
- R3: After a vertical sync trailing edge, the frozen value is sent most significant bit first, one bit per horizontal sync leading edge, over the next 11 such edges. The output register takes each bit on the clock edge that samples the horizontal sync low for the first time, and holds it until the next horizontal sync leading edge.
- R4: The output is low at all times outside the 11 bit slots. It goes low on the 12th horizontal sync leading edge after the trailing edge, and it stays low while vertical sync is low.
- R5: A horizontal sync leading edge in the same clock cycle as the vertical sync trailing edge is counted as a line, but it does not start a bit slot. The first slot is the next leading edge.
- R6: A vertical sync leading edge during serialization drops the bits not yet sent. The output is low from the following clock cycle.
- R7: While reset is asserted (rstN low), the output is low. The frozen value is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| hSyncN | input | 1 | Horizontal sync, active low, synchronous to clk |
| vSyncN | input | 1 | Vertical sync, active low, synchronous to clk |
| fmtOut | output | 1 | Serial lines-per-frame stream, MSB first |

## Verification
A horizontal sync leading edge can land in the same cycle as either vertical sync edge. At the leading edge it must be counted into the field that is ending. At the trailing edge it must be counted but must not open a bit slot. The stimulus generator places vertical sync transitions either on the first cycle of a line or a few cycles into it, chosen at random and in directed fields, so both collisions occur many times. Every cycle's output is compared with an expectation built from the rules above. The 11 bits received are also assembled and compared with twice the line count the bench itself issued. A misattributed edge therefore shows up as a word off by two or as a shifted bit stream.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

  // strobes from the sequencer to the datapath, all single-cycle
  typedef struct packed {
    logic countEn;    // horizontal sync leading edge this cycle
    logic latchEn;    // vertical sync leading edge: freeze field count
    logic loadShift;  // vertical sync trailing edge: arm shift register
    logic shiftEn;    // present next bit on the pin
    logic clearOut;   // force the pin low
  } lpfStrobe_t;

endpackage

// File: rtl/lpf_ctrl.sv
module lpf_ctrl
  import lpf_pkg::*;
#(
  parameter int NBITS = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hSyncN,
  input  logic       vSyncN,
  output lpfStrobe_t strb
);

  localparam int SLOT_W = $clog2(NBITS + 1);
  localparam logic [SLOT_W-1:0] SLOT_FULL = SLOT_W'(NBITS);

  logic              hPrev;
  logic              vPrev;
  logic              sending;
  logic [SLOT_W-1:0] slotsLeft;
  logic              hLead;
  logic              vLead;
  logic              vTrail;

  assign hLead  = hPrev & ~hSyncN;
  assign vLead  = vPrev & ~vSyncN;
  assign vTrail = ~vPrev & vSyncN;

  always_comb begin
    strb         = '0;
    strb.countEn = hLead;
    strb.latchEn = vLead;
    if (vLead) begin
      strb.clearOut = 1'b1;
    end else if (vTrail) begin
      strb.loadShift = 1'b1;
    end else if (hLead && sending) begin
      if (slotsLeft != '0) strb.shiftEn  = 1'b1;
      else                 strb.clearOut = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hPrev     <= 1'b1;
      vPrev     <= 1'b1;
      sending   <= 1'b0;
      slotsLeft <= '0;
    end else begin
      hPrev <= hSyncN;
      vPrev <= vSyncN;
      if (vLead) begin
        sending   <= 1'b0;
        slotsLeft <= '0;
      end else if (vTrail) begin
        sending   <= 1'b1;
        slotsLeft <= SLOT_FULL;
      end else if (strb.shiftEn) begin
        slotsLeft <= slotsLeft - 1'b1;
      end else if (strb.clearOut) begin
        sending <= 1'b0;
      end
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadShift, strb.shiftEn, strb.clearOut}));

  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hSyncN && vSyncN == vPrev) |=> $stable(slotsLeft));

  // R3
  always_comb begin
    slot_range_chk: assert (slotsLeft <= SLOT_FULL);
  end

endmodule

// File: rtl/lpf_datapath.sv
module lpf_datapath
  import lpf_pkg::*;
#(
  parameter int NBITS = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  lpfStrobe_t strb,
  output logic       fmtOut
);

  localparam logic [NBITS-1:0] WORD_MAX = {NBITS{1'b1}};
  localparam logic [NBITS+1:0] WIDE_MAX = {2'b00, WORD_MAX};

  logic [NBITS-1:0] cnt;
  logic [NBITS-1:0] latched;
  logic [NBITS-1:0] shiftReg;
  logic [NBITS:0]   sum;
  logic [NBITS+1:0] dbl;
  logic [NBITS-1:0] satWord;

  assign sum     = {1'b0, cnt} + {{NBITS{1'b0}}, strb.countEn};
  assign dbl     = {sum, 1'b0};
  assign satWord = (dbl > WIDE_MAX) ? WORD_MAX : dbl[NBITS-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      latched <= '0;
    end else if (strb.latchEn) begin
      latched <= satWord;
      cnt     <= '0;
    end else if (strb.countEn && cnt != WORD_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      fmtOut   <= 1'b0;
    end else if (strb.clearOut) begin
      fmtOut <= 1'b0;
    end else if (strb.loadShift) begin
      shiftReg <= latched;
    end else if (strb.shiftEn) begin
      fmtOut   <= shiftReg[NBITS-1];
      shiftReg <= {shiftReg[NBITS-2:0], 1'b0};
    end
  end

  // R1
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && !strb.latchEn) |=> cnt >= $past(cnt));

  // R2
  even_or_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchEn |=> (!latched[0] || latched == WORD_MAX));

endmodule

// File: rtl/lpf_reporter.sv
module lpf_reporter
  import lpf_pkg::*;
#(
  parameter int NBITS = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic hSyncN,
  input  logic vSyncN,
  output logic fmtOut
);

  lpfStrobe_t strb;

  lpf_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .hSyncN (hSyncN),
    .vSyncN (vSyncN),
    .strb   (strb)
  );

  lpf_datapath #(.NBITS(NBITS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .fmtOut (fmtOut)
  );

  // R4
  fmt_low_in_vsync_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vSyncN |=> !fmtOut);

endmodule

// File: tb/lpf_reporter_tb.sv
`timescale 1ns/1ps
module lpf_reporter_tb;

  localparam int NB = 11;
  localparam int WMAX = 2047;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hSyncN = 1'b1;
  logic vSyncN = 1'b1;
  logic fmtOut;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  lpf_reporter #(.NBITS(NB)) u_dut (
    .clk(clk), .rstN(rstN), .hSyncN(hSyncN), .vSyncN(vSyncN), .fmtOut(fmtOut)
  );

  // bench expectation state, derived from the requirements
  logic ph = 1'b1, pv = 1'b1;
  int   lines = 0;
  int   expLatched = 0;
  int   shiftW = 0;
  int   trailWord = 0;
  bit   active = 0;
  int   rem = 0;
  logic expOut = 1'b0;
  int   rxWord = 0;
  int   rxCnt = 0;

  function automatic int expWord(int n);
    return (2 * n > WMAX) ? WMAX : 2 * n;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: fmtOut=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic h, logic v);
    logic hl, vl, vt;
    bit   slotBit;
    string tag;
    hl = ph & ~h;
    vl = pv & ~v;
    vt = ~pv & v;
    slotBit = 0;
    tag = "R4";
    hSyncN = h;
    vSyncN = v;
    if (vl) begin
      if (hl) lines++;
      expLatched = expWord(lines);
      lines = 0;
      if (active) tag = "R6";
      active = 0;
      rem = 0;
      expOut = 1'b0;
    end else if (vt) begin
      if (hl) begin
        lines++;
        tag = "R5";
      end
      shiftW = expLatched;
      trailWord = expLatched;
      active = 1;
      rem = NB;
      rxCnt = 0;
      rxWord = 0;
    end else if (hl) begin
      lines++;
      if (active && rem > 0) begin
        expOut = shiftW[rem-1];
        rem--;
        slotBit = 1;
        tag = "R3";
      end else if (active) begin
        expOut = 1'b0;
        active = 0;
      end
    end
    ph = h;
    pv = v;
    @(posedge clk);
    @(negedge clk);
    check(tag, fmtOut, expOut);
    if (slotBit) begin
      rxWord = (rxWord << 1) | int'(fmtOut);
      rxCnt++;
      if (rxCnt == NB) begin
        checks++;
        if (rxWord != trailWord) begin
          fails++;
          $display("FAIL %s: word=%0d expected %0d", (trailWord == WMAX) ? "R2" : "R1",
                   rxWord, trailWord);
        end
      end
    end
  endtask

  // n lines of hp cycles, sync low for pw cycles; vertical sync low from
  // line 0 to line vl, each transition on the line start or pw cycles in
  task automatic field(int n, int hp, int pw, int vl, bit coLead, bit coTrail);
    int startPos, endPos, pos;
    startPos = coLead ? 0 : pw;
    endPos   = vl * hp + (coTrail ? 0 : pw);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < hp; c++) begin
        pos = i * hp + c;
        cyc((c < pw) ? 1'b0 : 1'b1, (pos >= startPos && pos < endPos) ? 1'b0 : 1'b1);
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int seedDummy;
    int n, hp, pw, vl;
    seedDummy = $urandom(20240611);
    // R7 reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7", fmtOut, 1'b0);
    end
    rstN = 1'b1;
    // R1 short field, then the 1023-line field that reports 2046
    field(20, 8, 2, 3, 0, 0);
    field(1023, 8, 2, 3, 0, 0);
    // R6 abort after five ones of 2046
    field(8, 8, 2, 2, 0, 0);
    // R2 saturation
    field(1100, 8, 2, 3, 0, 0);
    field(30, 8, 2, 3, 0, 0);
    // R5 and R1 coincident edges
    field(40, 7, 3, 2, 1, 1);
    field(45, 9, 2, 3, 1, 0);
    field(50, 6, 2, 1, 0, 1);
    field(30, 8, 2, 2, 0, 0);
    // random fields
    for (int k = 0; k < 25; k++) begin
      vl = 1 + int'($urandom_range(3));
      n  = vl + 13 + int'($urandom_range(180));
      hp = 6 + int'($urandom_range(6));
      pw = 1 + int'($urandom_range(hp / 2 - 1));
      field(n, hp, pw, vl, bit'($urandom_range(1)), bit'($urandom_range(1)));
    end
    field(30, 8, 2, 2, 0, 0);
    finish_run();
  end

endmodule